// File: doc/BRIEF.md
# Per-Queue Tail Write Aggregator

This block forms the write side of a packet buffer that keeps many logical FIFO queues. Small fixed-size cells arrive one per cycle, each tagged with the number of the queue it belongs to. The block keeps the cells in a small on-chip tail store that is split by queue. Cells from different queues never share a wide block. Once a queue holds at least one full block's worth of cells, it can be written out. The whole block then leaves as one wide word that a bank of parallel slow memories stores in a single access.

The wide memory accepts one block per access slot, and a slot comes round every `SLOT_CYC` cycles. When more than one queue is ready in the same slot, the lowest-numbered queue goes first. A queue that is waiting for its slot keeps taking cells. If a cell arrives for a queue whose tail store is full, the cell is dropped and a sticky error flag is raised. The block exports the occupancy of every queue.

Top module: `tail_aggregator`

## Requirements
- R1: While reset is asserted and after it is released, `blk_valid` is 0, every occupancy field is 0 and `ovf_err` is 0.
- R2: An accepted cell raises the occupancy of its own queue by one on the next clock edge and leaves every other queue's occupancy unchanged. Occupancy of queue i is `occ_o[i*OW +: OW]`.
- R3: A queue is written out only when it holds at least `CELLS_PER_BLK` cells. The block carries that queue's oldest `CELLS_PER_BLK` cells in arrival order, with the oldest cell in the lowest `CELL_W` bits of `blk_data`, and the occupancy of the queue falls by `CELLS_PER_BLK`.
- R4: The slot counter starts at 0 when reset is released and advances on every edge. A block is issued only on an edge where the counter equals `SLOT_CYC-1`. `blk_valid` is then high for exactly the following cycle, and this happens whenever at least one queue is eligible.
- R5: When several queues are eligible at a slot, the queue with the lowest index is written.
- R6: A queue keeps accepting cells while it waits for a slot. A cell that arrives on the same edge as its queue's block write is accepted, and the occupancy becomes old − `CELLS_PER_BLK` + 1.
- R7: A cell for a queue that holds `DEPTH_BLKS*CELLS_PER_BLK` cells and is not being drained on that edge is dropped, and that queue's occupancy stays the same. `ovf_err` rises on the next edge and stays at 1 until reset.
- R8: `blk_qid` names the queue whose cells make up `blk_data`. No block ever holds cells of two queues.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cell_valid | input | 1 | A cell is presented this cycle |
| cell_qid | input | QW | Queue number of the cell |
| cell_data | input | CELL_W | Cell payload |
| blk_valid | output | 1 | Wide block write this cycle |
| blk_qid | output | QW | Queue number of the block |
| blk_data | output | CELLS_PER_BLK*CELL_W | Block payload, oldest cell in the low bits |
| occ_o | output | NQ*OW | Occupancy of every queue, queue 0 in the low bits |
| ovf_err | output | 1 | Sticky tail overflow flag |

## Verification
The hardest case to reach is a tail overflow. Reaching it needs a queue to gain cells faster than slots drain it, while other queues also compete for those slots. The stimulus drives a long back-to-back run of cells into queue 0. Because a slot comes only once every eight cycles, queue 0 fills its store and then takes more cells. Priority contention is set up by first bringing three queues just below the threshold and then pushing them over it in the reverse of their index order.

// File: rtl/tail_aggregator.sv
module tail_aggregator #(
  parameter int NQ            = 4,
  parameter int CELL_W        = 16,
  parameter int CELLS_PER_BLK = 4,
  parameter int DEPTH_BLKS    = 2,
  parameter int SLOT_CYC      = 8,
  localparam int QW    = (NQ > 1) ? $clog2(NQ) : 1,
  localparam int DEPTH = DEPTH_BLKS * CELLS_PER_BLK,
  localparam int PW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int OW    = $clog2(DEPTH + 1),
  localparam int SW    = (SLOT_CYC > 1) ? $clog2(SLOT_CYC) : 1,
  localparam int BLK_W = CELLS_PER_BLK * CELL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cell_valid,
  input  logic [QW-1:0]     cell_qid,
  input  logic [CELL_W-1:0] cell_data,
  output logic              blk_valid,
  output logic [QW-1:0]     blk_qid,
  output logic [BLK_W-1:0]  blk_data,
  output logic [NQ*OW-1:0]  occ_o,
  output logic              ovf_err
);

  logic [CELL_W-1:0] mem [NQ][DEPTH];
  logic [PW-1:0]     wp  [NQ];
  logic [PW-1:0]     rp  [NQ];
  logic [OW-1:0]     occ [NQ];
  logic [SW-1:0]     slot_cnt;
  logic [NQ-1:0]     elig;
  logic [QW-1:0]     sel;
  logic              slot, drain, accept;

  assign slot  = (slot_cnt == SW'(SLOT_CYC - 1));
  assign drain = slot && (|elig);

  always_comb begin
    sel = '0;
    for (int i = NQ - 1; i >= 0; i--)
      if (elig[i]) sel = QW'(i);
  end

  assign accept = cell_valid &&
                  ((occ[cell_qid] < OW'(DEPTH)) || (drain && sel == cell_qid));

  always_ff @(posedge clk) begin
    if (!rst_n) slot_cnt <= '0;
    else        slot_cnt <= slot ? '0 : slot_cnt + 1'b1;
  end

  for (genvar i = 0; i < NQ; i++) begin : g_q
    logic wr, rd;
    assign elig[i] = (occ[i] >= OW'(CELLS_PER_BLK));
    assign wr = accept && (cell_qid == QW'(i));
    assign rd = drain && (sel == QW'(i));
    assign occ_o[i*OW +: OW] = occ[i];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        wp[i]  <= '0;
        rp[i]  <= '0;
        occ[i] <= '0;
      end else begin
        if (wr) wp[i] <= (wp[i] == PW'(DEPTH - 1)) ? '0 : wp[i] + 1'b1;
        if (rd) rp[i] <= (rp[i] == PW'(DEPTH - CELLS_PER_BLK)) ? '0
                                                             : rp[i] + PW'(CELLS_PER_BLK);
        occ[i] <= occ[i] + OW'(wr) - (rd ? OW'(CELLS_PER_BLK) : '0);
      end
    end

    always_ff @(posedge clk)
      if (wr) mem[i][wp[i]] <= cell_data;

    p_occ_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
      occ[i] <= OW'(DEPTH));

    p_drain_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (blk_valid && blk_qid == QW'(i)) |-> $past(occ[i]) >= OW'(CELLS_PER_BLK));

    if (i > 0) begin : g_prio
      p_lowest_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (blk_valid && blk_qid == QW'(i)) |-> $past(elig[i-1:0]) == '0);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      blk_valid <= 1'b0;
      blk_qid   <= '0;
      blk_data  <= '0;
      ovf_err   <= 1'b0;
    end else begin
      blk_valid <= drain;
      if (drain) begin
        blk_qid <= sel;
        for (int k = 0; k < CELLS_PER_BLK; k++)
          blk_data[k*CELL_W +: CELL_W] <= mem[sel][rp[sel] + PW'(k)];
      end
      if (cell_valid && !accept) ovf_err <= 1'b1;
    end
  end

  p_err_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_err |=> ovf_err);

  if (SLOT_CYC > 1) begin : g_gap
    p_one_per_slot_r4: assert property (@(posedge clk) disable iff (!rst_n)
      blk_valid |=> !blk_valid);
  end

endmodule

// File: tb/test_tail_aggregator.sv
module test_tail_aggregator;
  localparam int NQ = 4, CW = 16, CPB = 4, DB = 2, SC = 8;
  localparam int QW = 2, DEPTH = DB * CPB, OW = $clog2(DEPTH + 1), BW = CPB * CW;

  logic clk = 0, rst_n = 0;
  logic cell_valid = 0;
  logic [QW-1:0] cell_qid = 0;
  logic [CW-1:0] cell_data = 0;
  logic blk_valid, ovf_err;
  logic [QW-1:0] blk_qid;
  logic [BW-1:0] blk_data;
  logic [NQ*OW-1:0] occ_o;

  tail_aggregator #(.NQ(NQ), .CELL_W(CW), .CELLS_PER_BLK(CPB),
                    .DEPTH_BLKS(DB), .SLOT_CYC(SC)) i_tail_aggregator (
    .clk(clk), .rst_n(rst_n), .cell_valid(cell_valid), .cell_qid(cell_qid),
    .cell_data(cell_data), .blk_valid(blk_valid), .blk_qid(blk_qid),
    .blk_data(blk_data), .occ_o(occ_o), .ovf_err(ovf_err));

  always #4 clk = ~clk;

  int checks = 0, errors = 0;
  logic [CW-1:0] mq [NQ][$];
  int exp_q[$];
  logic [BW-1:0] exp_d[$];
  int mcnt = 0;
  bit merr = 0;
  logic [CW-1:0] seq = 16'h0100;

  task automatic check(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [NQ*OW-1:0] model_occ();
    logic [NQ*OW-1:0] v;
    for (int i = 0; i < NQ; i++) v[i*OW +: OW] = OW'(mq[i].size());
    return v;
  endfunction

  task automatic step(input bit v, input int q);
    logic [BW-1:0] blk;
    int s;
    bit pred;
    pred = 0;
    if (mcnt == SC - 1) begin
      s = -1;
      for (int i = NQ - 1; i >= 0; i--) if (mq[i].size() >= CPB) s = i;
      if (s >= 0) begin
        for (int k = 0; k < CPB; k++) blk[k*CW +: CW] = mq[s].pop_front();
        exp_q.push_back(s);
        exp_d.push_back(blk);
        pred = 1;
      end
    end
    if (v) begin
      seq++;
      if (mq[q].size() < DEPTH) mq[q].push_back(seq);
      else merr = 1;
    end
    mcnt = (mcnt + 1) % SC;
    cell_valid = v;
    cell_qid = QW'(q);
    cell_data = seq;
    @(posedge clk);
    @(negedge clk);
    cell_valid = 0;
    check(blk_valid == pred, "R4 block timing", 64'(blk_valid), 64'(pred));
    check(occ_o == model_occ(), "R2 R6 occupancy", 64'(occ_o), 64'(model_occ()));
    check(ovf_err == merr, "R7 overflow flag", 64'(ovf_err), 64'(merr));
  endtask

  always @(negedge clk) begin
    if (rst_n && blk_valid) begin
      if (exp_q.size() == 0) begin
        check(0, "R3 unexpected block", 64'(blk_qid), 64'hffff);
      end else begin
        int eq;
        logic [BW-1:0] ed;
        eq = exp_q.pop_front();
        ed = exp_d.pop_front();
        check(blk_qid == QW'(eq), "R5 R8 block queue", 64'(blk_qid), 64'(eq));
        check(blk_data == ed, "R3 block data", blk_data, ed);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int lcg;
    repeat (3) @(negedge clk);
    check(blk_valid == 0, "R1 reset blk_valid", 64'(blk_valid), 0);
    check(occ_o == 0, "R1 reset occupancy", 64'(occ_o), 0);
    check(ovf_err == 0, "R1 reset error", 64'(ovf_err), 0);
    rst_n = 1;

    // R2 R3: a single queue fills to one block
    for (int n = 0; n < CPB; n++) step(1, 2);
    repeat (10) step(0, 0);

    // R5 R6: three queues below threshold, then pushed over in reverse index order
    for (int n = 0; n < CPB - 1; n++) begin step(1, 3); step(1, 1); step(1, 0); end
    step(1, 3); step(1, 1); step(1, 0);
    for (int n = 0; n < 3; n++) step(1, 1);
    repeat (30) step(0, 0);

    // R7: back-to-back cells to queue 0 outrun the slots
    for (int n = 0; n < 24; n++) step(1, 0);
    repeat (40) step(0, 0);
    check(ovf_err == 1, "R7 sticky after idle", 64'(ovf_err), 1);

    // mixed traffic
    lcg = 7;
    for (int n = 0; n < 300; n++) begin
      lcg = (lcg * 1103515245 + 12345) & 32'h7fffffff;
      step(((lcg >> 8) & 3) != 0, (lcg >> 12) & 3);
    end
    repeat (60) step(0, 0);
    check(exp_q.size() == 0, "R3 all blocks seen", 64'(exp_q.size()), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule